// File: doc/BRIEF.md
# Card I/O Write Cycle Sequencer

This block is the host-side engine for one 16-bit I/O write to a removable memory card that is in PC-card I/O mode. A command carrying an address and a data word is accepted over a valid/ready handshake. The sequencer then drives the card address lines, the active-low card enable, the active-low register-select line, the data bus with its output enables, and the active-low I/O write strobe. Every edge is placed by a cycle counter. Each minimum time in nanoseconds is turned into clock cycles with a ceiling division by `CLK_PERIOD_NS`, so the cycle meets the setup, hold and width limits for any clock period.

Each pin has its own window around the strobe. Address, enable, register-select and data are all raised together at the start of the setup phase. The setup phase lasts as long as the longest setup need, and that includes the time the card takes to report its port width. After the strobe rises, each line is released when its own hold count runs out. Register-select is released on the same edge as the strobe. The card's 16-bit indicator is sampled once its settle time after the address appears. If the indicator reads high, the access is marked 8-bit and the high data byte stops being driven. A one-cycle done pulse ends the transaction.

Back-pressure rule: `cmd_ready` is high only while the sequencer is idle. A command transfers on a clock edge where `cmd_valid` and `cmd_ready` are both high. While a write is in progress, `cmd_valid` may stay high with any payload and has no effect. The requester may change or drop the command freely until it is accepted.

Top module: `card_iowr_seq`

## Requirements
- R1: After reset, and whenever idle, `cmd_ready`=1, `card_iowr_n`=1, `card_ce_n`=1, `card_reg_n`=1, both data output enables are 0 and `wr_done`=0. `cmd_ready` drops on the cycle after a command is accepted and stays low until the done cycle has ended. Commands offered while busy do not change the address or data being driven.
- R2: Each minimum time is converted to cycles as ceil(ns / CLK_PERIOD_NS). The setup phase lasts SU = max(address setup, enable setup, register setup, width-delay + 1) cycles. The strobe stays low for STB = max(strobe width, data setup − SU) cycles. The hold phase lasts HD = max(address hold, enable hold, data hold, 1) cycles.
- R3: `card_addr` carries the accepted address from the first setup cycle until the address-hold count (≥20 ns) after the strobe rises, which gives at least 70 ns before the strobe falls. Outside that window it is driven as all zeros.
- R4: `card_ce_n` is low from the first setup cycle (≥5 ns before the strobe falls) until the enable-hold count (≥20 ns) after the strobe rises.
- R5: `card_reg_n` is low from the first setup cycle (≥5 ns before the strobe falls) and rises on the same edge as `card_iowr_n`.
- R6: `card_iowr_n` is low for exactly STB cycles, which is at least 165 ns.
- R7: `card_data_oe_lo` is high from the first setup cycle until the data-hold count (≥30 ns) after the strobe rises, which gives at least 60 ns of data before the rise. While an enable is high, its byte of `card_data` equals the accepted data. After the hold count both enables are 0.
- R8: `card_iois16_n` is sampled at the edge ending setup cycle W = ceil(35 ns / CLK_PERIOD_NS), counting the first setup cycle as 0. A high value sets `wr_byte_mode`=1 and drops `card_data_oe_hi` from setup cycle W+1 onward. A low value keeps `card_data_oe_hi` equal to `card_data_oe_lo`. `wr_byte_mode` keeps its value until the next command is accepted.
- R9: `wr_done` is high for exactly one cycle, SU+STB+HD cycles after the first setup cycle. `cmd_ready` returns high on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Write command offered |
| cmd_ready | output | 1 | Sequencer idle; command accepted when both are high |
| cmd_addr | input | ADDR_W | I/O address of the command |
| cmd_data | input | 16 | Data word of the command |
| card_addr | output | ADDR_W | Card address lines |
| card_ce_n | output | 1 | Card enable, active low |
| card_reg_n | output | 1 | Register-space select, active low |
| card_iowr_n | output | 1 | I/O write strobe, active low |
| card_data | output | 16 | Card data bus value |
| card_data_oe_lo | output | 1 | Output enable for data bits 7:0 |
| card_data_oe_hi | output | 1 | Output enable for data bits 15:8 |
| card_iois16_n | input | 1 | Card port-width indicator, low for a 16-bit port |
| wr_done | output | 1 | One-cycle completion pulse |
| wr_byte_mode | output | 1 | Last access ran as 8-bit |

## Verification
The bench sweeps every nonzero address of a 4-bit address configuration. It pairs each address with a data word derived from it and alternates the card between a 16-bit and an 8-bit port. This separates the high-byte enable and the width flag for the two widths, and catches any address or data that leaks between neighbouring transactions. A second command is held valid throughout each write, so any loss of back-pressure would show up as a changed address or data word. For every pin, the cycle of each edge is timestamped. Each window is compared both with its exact cycle count and with its minimum in nanoseconds.

// File: rtl/card_iowr_pkg.sv
package card_iowr_pkg;

  localparam int DATA_W = 16;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_LOW   = 3'd2,
    ST_HOLD  = 3'd3,
    ST_DONE  = 3'd4
  } seq_state_t;

  // Smallest cycle count whose duration covers ns.
  function automatic int ns2cyc(input int ns, input int per);
    return (ns + per - 1) / per;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/card_iowr_fsm.sv
module card_iowr_fsm
  import card_iowr_pkg::*;
#(
  parameter int SU_C  = 9,
  parameter int STB_C = 21,
  parameter int HD_C  = 4,
  parameter int CW    = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output seq_state_t       state,
  output logic [CW-1:0]    cnt
);

  localparam logic [CW-1:0] SU_LAST  = CW'(SU_C - 1);
  localparam logic [CW-1:0] STB_LAST = CW'(STB_C - 1);
  localparam logic [CW-1:0] HD_LAST  = CW'(HD_C - 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      unique case (state)
        ST_IDLE: begin
          cnt <= '0;
          if (start) state <= ST_SETUP;
        end
        ST_SETUP: begin
          if (cnt == SU_LAST) begin
            state <= ST_LOW;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_LOW: begin
          if (cnt == STB_LAST) begin
            state <= ST_HOLD;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        ST_HOLD: begin
          if (cnt == HD_LAST) begin
            state <= ST_DONE;
            cnt   <= '0;
          end else begin
            cnt <= cnt + 1'b1;
          end
        end
        default: begin
          state <= ST_IDLE;
          cnt   <= '0;
        end
      endcase
    end
  end

endmodule

// File: rtl/card_iowr_width.sv
module card_iowr_width
  import card_iowr_pkg::*;
#(
  parameter int WID_C = 5,
  parameter int CW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  seq_state_t    state,
  input  logic [CW-1:0] cnt,
  input  logic          iois16_n,
  output logic          byte_mode
);

  localparam logic [CW-1:0] SAMPLE_AT = CW'(WID_C);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      byte_mode <= 1'b0;
    end else if (start) begin
      byte_mode <= 1'b0;
    end else if (state == ST_SETUP && cnt == SAMPLE_AT) begin
      byte_mode <= iois16_n;
    end
  end

endmodule

// File: rtl/card_iowr_pins.sv
module card_iowr_pins
  import card_iowr_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int CW        = 5,
  parameter int ADDR_HD_C = 2,
  parameter int CE_HD_C   = 2,
  parameter int DATA_HD_C = 3
) (
  input  seq_state_t        state,
  input  logic [CW-1:0]     cnt,
  input  logic [ADDR_W-1:0] addr_q,
  input  logic [DATA_W-1:0] data_q,
  input  logic              byte_mode,
  output logic [ADDR_W-1:0] card_addr,
  output logic              card_ce_n,
  output logic              card_reg_n,
  output logic              card_iowr_n,
  output logic [DATA_W-1:0] card_data,
  output logic              card_data_oe_lo,
  output logic              card_data_oe_hi
);

  logic active, in_hold, addr_on, ce_on, data_on;

  always_comb begin
    active  = (state == ST_SETUP) || (state == ST_LOW);
    in_hold = (state == ST_HOLD);
    addr_on = active || (in_hold && (cnt < CW'(ADDR_HD_C)));
    ce_on   = active || (in_hold && (cnt < CW'(CE_HD_C)));
    data_on = active || (in_hold && (cnt < CW'(DATA_HD_C)));

    card_addr       = addr_on ? addr_q : '0;
    card_ce_n       = !ce_on;
    card_reg_n      = !active;
    card_iowr_n     = (state != ST_LOW);
    card_data_oe_lo = data_on;
    card_data_oe_hi = data_on && !byte_mode;
    card_data       = {card_data_oe_hi ? data_q[15:8] : 8'h00,
                       card_data_oe_lo ? data_q[7:0]  : 8'h00};
  end

endmodule

// File: rtl/card_iowr_seq.sv
module card_iowr_seq
  import card_iowr_pkg::*;
#(
  parameter int CLK_PERIOD_NS = 10,
  parameter int ADDR_W        = 10,
  parameter int T_ADDR_SU_NS  = 70,
  parameter int T_ADDR_HD_NS  = 20,
  parameter int T_CE_SU_NS    = 5,
  parameter int T_CE_HD_NS    = 20,
  parameter int T_REG_SU_NS   = 5,
  parameter int T_DATA_SU_NS  = 60,
  parameter int T_DATA_HD_NS  = 30,
  parameter int T_STB_W_NS    = 165,
  parameter int T_WID_DLY_NS  = 35
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [15:0]       cmd_data,
  output logic [ADDR_W-1:0] card_addr,
  output logic              card_ce_n,
  output logic              card_reg_n,
  output logic              card_iowr_n,
  output logic [15:0]       card_data,
  output logic              card_data_oe_lo,
  output logic              card_data_oe_hi,
  input  logic              card_iois16_n,
  output logic              wr_done,
  output logic              wr_byte_mode
);

  localparam int ADDR_SU_C = ns2cyc(T_ADDR_SU_NS, CLK_PERIOD_NS);
  localparam int ADDR_HD_C = ns2cyc(T_ADDR_HD_NS, CLK_PERIOD_NS);
  localparam int CE_SU_C   = ns2cyc(T_CE_SU_NS,   CLK_PERIOD_NS);
  localparam int CE_HD_C   = ns2cyc(T_CE_HD_NS,   CLK_PERIOD_NS);
  localparam int REG_SU_C  = ns2cyc(T_REG_SU_NS,  CLK_PERIOD_NS);
  localparam int DATA_SU_C = ns2cyc(T_DATA_SU_NS, CLK_PERIOD_NS);
  localparam int DATA_HD_C = ns2cyc(T_DATA_HD_NS, CLK_PERIOD_NS);
  localparam int STB_W_C   = ns2cyc(T_STB_W_NS,   CLK_PERIOD_NS);
  localparam int WID_C     = ns2cyc(T_WID_DLY_NS, CLK_PERIOD_NS);

  localparam int SU_C  = imax(imax(ADDR_SU_C, CE_SU_C), imax(REG_SU_C, WID_C + 1));
  localparam int STB_C = imax(STB_W_C, DATA_SU_C - SU_C);
  localparam int HD_C  = imax(imax(ADDR_HD_C, CE_HD_C), imax(DATA_HD_C, 1));
  localparam int CW    = $clog2(imax(imax(SU_C, STB_C), HD_C) + 1);

  seq_state_t        state;
  logic [CW-1:0]     cnt;
  logic              start;
  logic [ADDR_W-1:0] addr_q;
  logic [15:0]       data_q;

  assign cmd_ready = (state == ST_IDLE);
  assign start     = cmd_valid && cmd_ready;
  assign wr_done   = (state == ST_DONE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (start) begin
      addr_q <= cmd_addr;
      data_q <= cmd_data;
    end
  end

  card_iowr_fsm #(
    .SU_C(SU_C), .STB_C(STB_C), .HD_C(HD_C), .CW(CW)
  ) u_fsm (
    .clk(clk), .rst_n(rst_n), .start(start), .state(state), .cnt(cnt)
  );

  card_iowr_width #(
    .WID_C(WID_C), .CW(CW)
  ) u_width (
    .clk(clk), .rst_n(rst_n), .start(start), .state(state), .cnt(cnt),
    .iois16_n(card_iois16_n), .byte_mode(wr_byte_mode)
  );

  card_iowr_pins #(
    .ADDR_W(ADDR_W), .CW(CW), .ADDR_HD_C(ADDR_HD_C),
    .CE_HD_C(CE_HD_C), .DATA_HD_C(DATA_HD_C)
  ) u_pins (
    .state(state), .cnt(cnt), .addr_q(addr_q), .data_q(data_q),
    .byte_mode(wr_byte_mode), .card_addr(card_addr), .card_ce_n(card_ce_n),
    .card_reg_n(card_reg_n), .card_iowr_n(card_iowr_n), .card_data(card_data),
    .card_data_oe_lo(card_data_oe_lo), .card_data_oe_hi(card_data_oe_hi)
  );

endmodule

// File: rtl/card_iowr_seq_chk.sv
module card_iowr_seq_chk #(
  parameter int ADDR_W = 10,
  parameter int STB_C  = 17
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic [ADDR_W-1:0] card_addr,
  input logic              card_ce_n,
  input logic              card_reg_n,
  input logic              card_iowr_n,
  input logic              card_data_oe_lo,
  input logic              card_data_oe_hi,
  input logic              wr_done,
  input logic              wr_byte_mode
);

  logic [15:0] low_run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           low_run <= '0;
    else if (card_iowr_n) low_run <= '0;
    else                  low_run <= low_run + 1'b1;
  end

  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> (card_iowr_n && card_ce_n && card_reg_n && !card_data_oe_lo));

  a_r3_addr_steady: assert property (@(posedge clk) disable iff (!rst_n)
    (!card_iowr_n && !$fell(card_iowr_n)) |-> $stable(card_addr));

  a_r4_ce_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !card_iowr_n |-> !card_ce_n);

  a_r5_reg_with_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_iowr_n) |-> card_reg_n);

  a_r6_strobe_width: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(card_iowr_n) |-> (low_run >= 16'(STB_C)));

  a_r7_data_covers_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !card_iowr_n |-> card_data_oe_lo);

  a_r8_hi_byte_off: assert property (@(posedge clk) disable iff (!rst_n)
    wr_byte_mode |-> !card_data_oe_hi);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_done |=> !wr_done);

endmodule

bind card_iowr_seq card_iowr_seq_chk #(
  .ADDR_W(ADDR_W), .STB_C(STB_C)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_ready(cmd_ready), .card_addr(card_addr),
  .card_ce_n(card_ce_n), .card_reg_n(card_reg_n), .card_iowr_n(card_iowr_n),
  .card_data_oe_lo(card_data_oe_lo), .card_data_oe_hi(card_data_oe_hi),
  .wr_done(wr_done), .wr_byte_mode(wr_byte_mode)
);

// File: tb/card_iowr_seq_tb_top.sv
module card_iowr_seq_tb_top;

  localparam int P  = 8;
  localparam int AW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cmd_valid = 1'b0;
  logic          cmd_ready;
  logic [AW-1:0] cmd_addr = '0;
  logic [15:0]   cmd_data = '0;
  logic [AW-1:0] card_addr;
  logic          card_ce_n, card_reg_n, card_iowr_n;
  logic [15:0]   card_data;
  logic          card_data_oe_lo, card_data_oe_hi;
  logic          card_iois16_n;
  logic          wr_done, wr_byte_mode;
  logic          card16 = 1'b1;

  int errors = 0;
  int checks = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  assign card_iois16_n = !card16;

  card_iowr_seq #(.CLK_PERIOD_NS(P), .ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_addr(cmd_addr), .cmd_data(cmd_data), .card_addr(card_addr),
    .card_ce_n(card_ce_n), .card_reg_n(card_reg_n), .card_iowr_n(card_iowr_n),
    .card_data(card_data), .card_data_oe_lo(card_data_oe_lo),
    .card_data_oe_hi(card_data_oe_hi), .card_iois16_n(card_iois16_n),
    .wr_done(wr_done), .wr_byte_mode(wr_byte_mode)
  );

  function automatic int cdiv(input int ns);
    return (ns + P - 1) / P;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // R2: expected phase lengths
  int E_WID, E_SU, E_STB, E_HD, E_AHD, E_CHD, E_DHD;
  initial begin
    E_WID = cdiv(35);
    E_SU  = mx(mx(cdiv(70), cdiv(5)), mx(cdiv(5), E_WID + 1));
    E_STB = mx(cdiv(165), cdiv(60) - E_SU);
    E_AHD = cdiv(20);
    E_CHD = cdiv(20);
    E_DHD = cdiv(30);
    E_HD  = mx(mx(E_AHD, E_CHD), mx(E_DHD, 1));
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cycles, 100000);
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic run_txn(input logic [AW-1:0] a, input logic [15:0] d, input bit wide);
    int a_f = -1, a_l = -1, c_f = -1, c_l = -1, r_f = -1, r_l = -1;
    int s_f = -1, s_l = -1, lo_f = -1, lo_l = -1, hi_f = -1, hi_l = -1;
    int dn_f = -1, dn_n = 0, rdy_back = -1, bad_data = 0, bad_addr = 0;
    bit mode_at_done = 0;
    card16 = wide;
    @(negedge clk);
    cmd_valid = 1'b1; cmd_addr = a; cmd_data = d;
    @(posedge clk);
    // keep offering a different command while busy (R1 back-pressure)
    @(negedge clk);
    cmd_addr = ~a; cmd_data = ~d;
    for (int i = 0; i < 45; i++) begin
      if (i > 0) @(negedge clk);
      if (i == E_SU + E_STB + E_HD - 1) cmd_valid = 1'b0;
      if (card_addr != '0) begin
        if (a_f < 0) a_f = i;
        a_l = i;
        if (card_addr != a) bad_addr++;
      end
      if (!card_ce_n)   begin if (c_f < 0)  c_f = i;  c_l = i;  end
      if (!card_reg_n)  begin if (r_f < 0)  r_f = i;  r_l = i;  end
      if (!card_iowr_n) begin if (s_f < 0)  s_f = i;  s_l = i;  end
      if (card_data_oe_lo) begin
        if (lo_f < 0) lo_f = i;
        lo_l = i;
        if (card_data[7:0] != d[7:0]) bad_data++;
      end
      if (card_data_oe_hi) begin
        if (hi_f < 0) hi_f = i;
        hi_l = i;
        if (card_data[15:8] != d[15:8]) bad_data++;
      end
      if (wr_done) begin
        dn_n++;
        if (dn_f < 0) dn_f = i;
        mode_at_done = wr_byte_mode;
      end
      if (cmd_ready && rdy_back < 0) rdy_back = i;
    end
    // R3 address window
    chk(a_f == 0 && a_l == E_SU + E_STB + E_AHD - 1, "R3 addr window end", a_l, E_SU + E_STB + E_AHD - 1);
    chk((s_f - a_f) * P >= 70 && (a_l - s_l) * P >= 20, "R3 addr setup/hold ns", (s_f - a_f) * P, 70);
    chk(bad_addr == 0, "R3 addr value (R1 busy command ignored)", bad_addr, 0);
    // R4 enable
    chk(c_f == 0 && c_l == E_SU + E_STB + E_CHD - 1, "R4 enable window end", c_l, E_SU + E_STB + E_CHD - 1);
    chk((s_f - c_f) * P >= 5 && (c_l - s_l) * P >= 20, "R4 enable setup/hold ns", (c_l - s_l) * P, 20);
    // R5 register select
    chk(r_f == 0 && r_l == s_l, "R5 reg release with strobe", r_l, s_l);
    // R6 strobe
    chk(s_f == E_SU && (s_l - s_f + 1) == E_STB, "R6 strobe low cycles", s_l - s_f + 1, E_STB);
    chk((s_l - s_f + 1) * P >= 165, "R6 strobe width ns", (s_l - s_f + 1) * P, 165);
    // R7 data
    chk(lo_f == 0 && lo_l == E_SU + E_STB + E_DHD - 1, "R7 data low byte window", lo_l, E_SU + E_STB + E_DHD - 1);
    chk((s_l + 1 - lo_f) * P >= 60 && (lo_l - s_l) * P >= 30, "R7 data setup/hold ns", (lo_l - s_l) * P, 30);
    chk(bad_data == 0, "R7 data value (R1 busy command ignored)", bad_data, 0);
    // R8 width sampling
    if (wide) chk(hi_f == 0 && hi_l == lo_l, "R8 high byte on 16-bit", hi_l, lo_l);
    else      chk(hi_f == 0 && hi_l == E_WID, "R8 high byte off after sample", hi_l, E_WID);
    chk(mode_at_done == !wide, "R8 byte mode flag", int'(mode_at_done), int'(!wide));
    // R9 done
    chk(dn_n == 1 && dn_f == E_SU + E_STB + E_HD, "R9 done pulse cycle", dn_f, E_SU + E_STB + E_HD);
    chk(rdy_back == dn_f + 1, "R1 ready returns after done", rdy_back, dn_f + 1);
    chk(!card_data_oe_lo && !card_data_oe_hi && card_ce_n && card_iowr_n, "R1 idle pins after write",
        int'(card_data_oe_lo), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(cmd_ready && card_iowr_n && card_ce_n && card_reg_n && !card_data_oe_lo &&
        !card_data_oe_hi && !wr_done, "R1 reset state", int'(cmd_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk(cmd_ready && card_iowr_n, "R1 idle after reset", int'(cmd_ready), 1);
    for (int a = 1; a < 16; a++) begin
      run_txn(AW'(a), 16'((a * 16'h1357) ^ 16'hA5C3), (a % 2) == 1);
    end
    run_txn(4'hF, 16'hFFFF, 1'b0);
    run_txn(4'h1, 16'h0000, 1'b1);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule